// File: doc/BRIEF.md
# Memory Bank Interlock Priority Arbiter

This block guards a set of memory banks that cycle independently of each other. Each clock of the block is one major cycle. In each major cycle, every requester may present one access request that names a target bank. The requesters fall into three classes: DMA channels, one I/O processor and compute units. The block answers every valid request with either go or locked-out. Each answer is registered and appears one cycle after the request. Address decoding, bus slot timing and data movement are handled elsewhere.

A bank that is granted is held busy for the whole next major cycle. Any requester that targets it during that cycle is locked out and retries later. A DMA channel or the I/O processor that is locked out leaves a reservation on the bank. The reservation records the requester's class. While it stands, classes below that level cannot start on the bank, even when the bank is free again. This keeps the higher classes from being starved. Requesters are packed in one flat index order: the DMA channels first, then the I/O processor, then the compute units. A lower index means a higher priority, both within a class and between classes.

Top module: `bank_interlock_arb`

## Requirements
- R1: After reset, all banks are free and no reservation exists, so a lone request to any bank is granted; during reset `res_valid`, `res_go` and `res_lock` are all 0.
- R2: A valid request made at clock edge k is answered after edge k with `res_valid`=1 and exactly one of its `res_go`/`res_lock` bits set.
- R3: A bank granted in one cycle locks out every request to it in the next cycle, and it may be granted again in the cycle after that.
- R4: Among eligible requests to one free bank, only one is granted. DMA beats the I/O processor, and the I/O processor beats the compute units. The rest are locked out.
- R5: Within a class, the lowest index wins. Compute unit 0 (index NDMA+1) beats compute unit 1, and DMA 0 beats DMA 1.
- R6: Requests to distinct free, unreserved banks in the same cycle are all granted.
- R7: A locked-out DMA (level 3) or I/O processor (level 2) reserves the bank at its level. Requests of a lower level to that bank are then locked out, even while the bank is not busy.
- R8: A grant on a bank clears its reservation in that cycle. After that, lower levels may again be granted there.
- R9: Only a lockout of a strictly higher level replaces an existing reservation. After a DMA lockout replaces an I/O reservation, the I/O processor is itself locked out on that bank until a DMA is granted there.
- R10: A request whose valid bit is 0 gets neither go nor locked-out, and it does not block a valid request to the same bank.
- R11: A bank index of NBANK or above is always locked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one major cycle per period |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Per-requester request valid, index order DMA, I/O, compute |
| req_bank | input | NREQ*BW | Target bank per requester, requester r at bits [r*BW +: BW] |
| res_valid | output | 1 | Answers for the previous cycle's requests are present |
| res_go | output | NREQ | Requester was granted its bank |
| res_lock | output | NREQ | Requester was locked out and must retry |

## Verification
Two functions can fall on the same bank in the same cycle. A grant clears the bank's reservation, and a lockout of an equal-level loser installs a fresh one. The bench provokes this by sending both DMA channels to a bank that the I/O processor has just reserved. It then judges the outcome by whether the I/O processor stays locked out on the freed bank two cycles later (takeover). Busy blocking and reservation blocking are also provoked apart from each other, and the bench sends each request a cycle after the bank's grant and again two cycles after it.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LV_NONE = 2'd0;
  localparam lvl_t LV_CU   = 2'd1;
  localparam lvl_t LV_IOP  = 2'd2;
  localparam lvl_t LV_DMA  = 2'd3;
  localparam int MAX_BANKS = 39;
endpackage

// File: rtl/bank_req_decode.sv
module bank_req_decode
  import bank_arb_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int NDMA  = 2,
  parameter int NREQ  = 5,
  parameter int BW    = 6
) (
  input  logic [NREQ-1:0]            req_valid,
  input  logic [NREQ*BW-1:0]         req_bank,
  output logic [NBANK-1:0][NREQ-1:0] hit_map,
  output lvl_t [NREQ-1:0]            lvl,
  output logic [NREQ-1:0]            oor
);
  for (genvar r = 0; r < NREQ; r++) begin : g_req
    localparam lvl_t RLVL = (r < NDMA) ? LV_DMA : ((r == NDMA) ? LV_IOP : LV_CU);
    logic [BW-1:0] tgt;
    assign tgt    = req_bank[r*BW +: BW];
    assign lvl[r] = RLVL;
    assign oor[r] = req_valid[r] && (tgt >= BW'(NBANK));
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign hit_map[b][r] = req_valid[r] && (tgt == BW'(b));
    end
  end
endmodule

// File: rtl/bank_slice.sv
module bank_slice
  import bank_arb_pkg::*;
#(
  parameter int NREQ = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  hit,
  input  lvl_t [NREQ-1:0]  lvl,
  output logic [NREQ-1:0]  win
);
  logic busy_q, busy_d;
  lvl_t resv_q, resv_d;
  lvl_t lock_max, win_lvl;
  logic [NREQ-1:0] elig;
  logic taken;

  always_comb begin
    taken   = 1'b0;
    win     = '0;
    win_lvl = LV_NONE;
    for (int r = 0; r < NREQ; r++) begin
      elig[r] = hit[r] && !busy_q && (lvl[r] >= resv_q);
      if (elig[r] && !taken) begin
        win[r]  = 1'b1;
        win_lvl = lvl[r];
        taken   = 1'b1;
      end
    end
    lock_max = LV_NONE;
    for (int r = 0; r < NREQ; r++) begin
      if (hit[r] && !win[r] && (lvl[r] > lock_max)) lock_max = lvl[r];
    end
    resv_d = taken ? LV_NONE : resv_q;
    if ((lock_max >= LV_IOP) && (lock_max > resv_d)) resv_d = lock_max;
    busy_d = taken;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      resv_q <= LV_NONE;
    end else begin
      busy_q <= busy_d;
      resv_q <= resv_d;
    end
  end

  // R4
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(win));
  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> (win == '0));
  // R7
  resv_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (|win) |-> (win_lvl >= resv_q));
  // R8
  resv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|win) && (lock_max < LV_IOP)) |=> (resv_q == LV_NONE));
endmodule

// File: rtl/bank_interlock_arb.sv
module bank_interlock_arb
  import bank_arb_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int NDMA  = 2,
  parameter int NCU   = 2,
  parameter int BW    = 6,
  localparam int NREQ = NDMA + 1 + NCU
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREQ-1:0]     req_valid,
  input  logic [NREQ*BW-1:0]  req_bank,
  output logic                res_valid,
  output logic [NREQ-1:0]     res_go,
  output logic [NREQ-1:0]     res_lock
);
  logic [NBANK-1:0][NREQ-1:0] hit_map;
  logic [NBANK-1:0][NREQ-1:0] win_map;
  lvl_t [NREQ-1:0]            lvl;
  logic [NREQ-1:0]            oor;
  logic [NREQ-1:0]            go_c, lock_c;

  bank_req_decode #(.NBANK(NBANK), .NDMA(NDMA), .NREQ(NREQ), .BW(BW)) u_dec (
    .req_valid (req_valid),
    .req_bank  (req_bank),
    .hit_map   (hit_map),
    .lvl       (lvl),
    .oor       (oor)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_slice
    bank_slice #(.NREQ(NREQ)) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit_map[b]),
      .lvl   (lvl),
      .win   (win_map[b])
    );
  end

  always_comb begin
    go_c = '0;
    for (int b = 0; b < NBANK; b++) go_c = go_c | win_map[b];
    lock_c = req_valid & ~go_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_go    <= '0;
      res_lock  <= '0;
    end else begin
      res_valid <= |req_valid;
      res_go    <= go_c;
      res_lock  <= lock_c;
    end
  end

  // R2
  go_lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) (res_go & res_lock) == '0);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> ((res_go | res_lock) == '0));
  // R11
  range_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|oor) |=> ((res_lock & $past(oor)) == $past(oor)));
endmodule

// File: tb/bank_interlock_arb_bench.sv
module bank_interlock_arb_bench;
  localparam int NBANK = 8, NDMA = 2, NCU = 2, BW = 6;
  localparam int NREQ = NDMA + 1 + NCU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0]    req_valid = '0;
  logic [NREQ*BW-1:0] req_bank = '0;
  logic               res_valid;
  logic [NREQ-1:0]    res_go, res_lock;

  int tests = 0, fails = 0;
  logic [NREQ-1:0] q_go[$];
  logic [NREQ-1:0] q_lock[$];
  string           q_tag[$];

  always #5 clk = ~clk;

  bank_interlock_arb #(.NBANK(NBANK), .NDMA(NDMA), .NCU(NCU), .BW(BW)) u_bank_interlock_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .res_valid(res_valid), .res_go(res_go), .res_lock(res_lock)
  );

  // Monitor: answers appear the cycle after the request (R2)
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      tests++;
      if (q_go.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected answer go=%b lock=%b expected none", res_go, res_lock);
      end else begin
        logic [NREQ-1:0] eg, el;
        string t;
        eg = q_go.pop_front(); el = q_lock.pop_front(); t = q_tag.pop_front();
        if (res_go !== eg || res_lock !== el) begin
          fails++;
          $display("FAIL %s go=%b lock=%b expected go=%b lock=%b", t, res_go, res_lock, eg, el);
        end
      end
    end
  end

  task automatic step(input logic [NREQ-1:0] v, input int b0, b1, b2, b3, b4,
                      input logic [NREQ-1:0] eg, input logic [NREQ-1:0] el, input string tag);
    @(negedge clk);
    req_valid = v;
    req_bank  = {BW'(b4), BW'(b3), BW'(b2), BW'(b1), BW'(b0)};
    q_go.push_back(eg); q_lock.push_back(el); q_tag.push_back(tag);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    tests++;
    if (res_valid !== 1'b0 || res_go !== '0 || res_lock !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs valid=%b go=%b lock=%b expected 0", res_valid, res_go, res_lock);
    end
    rst_n = 1'b1;
    // idx: 0 DMA0, 1 DMA1, 2 IOP, 3 CU0, 4 CU1
    step(5'b01000, 0,0,0,0,0, 5'b01000, 5'b00000, "R1 fresh bank grant");
    step(5'b10000, 0,0,0,0,0, 5'b00000, 5'b10000, "R3 busy next cycle");
    step(5'b10000, 0,0,0,0,0, 5'b10000, 5'b00000, "R3 free after one cycle");
    step(5'b11111, 1,2,3,4,5, 5'b11111, 5'b00000, "R6 distinct banks");
    step(5'b11111, 6,6,6,6,6, 5'b00001, 5'b11110, "R4 class priority");
    step(5'b11000, 0,0,0,7,7, 5'b01000, 5'b10000, "R5 compute tie");
    step(5'b01100, 0,0,6,6,0, 5'b00000, 5'b01100, "R7 reserved free bank");
    step(5'b00010, 0,6,0,0,0, 5'b00010, 5'b00000, "R8 holder level granted");
    step(5'b01000, 0,0,0,0,0, 5'b01000, 5'b00000, "R2 filler grant");
    step(5'b01000, 0,0,0,6,0, 5'b01000, 5'b00000, "R8 reservation cleared");
    step(5'b10000, 0,0,0,0,2, 5'b10000, 5'b00000, "R2 setup grant");
    step(5'b00100, 0,0,2,0,0, 5'b00000, 5'b00100, "R7 IOP reserves");
    step(5'b10011, 2,2,0,0,2, 5'b00001, 5'b10010, "R9 grant clears and DMA reserves");
    step(5'b00100, 0,0,2,0,0, 5'b00000, 5'b00100, "R3 busy again");
    step(5'b00100, 0,0,2,0,0, 5'b00000, 5'b00100, "R9 takeover blocks IOP");
    step(5'b00010, 0,2,0,0,0, 5'b00010, 5'b00000, "R9 DMA holder granted");
    step(5'b00001, 3,0,0,0,0, 5'b00001, 5'b00000, "R6 filler grant");
    step(5'b00100, 0,0,2,0,0, 5'b00100, 5'b00000, "R8 IOP after clear");
    step(5'b01000, 4,0,0,4,0, 5'b01000, 5'b00000, "R10 invalid request ignored");
    step(5'b10000, 0,0,0,0,9, 5'b00000, 5'b10000, "R11 out of range");
    step(5'b10001, 9,0,0,0,1, 5'b10000, 5'b00001, "R11 out of range DMA");
    @(negedge clk);
    req_valid = '0;
    repeat (3) @(negedge clk);
    tests++;
    if (q_go.size() != 0) begin
      fails++;
      $display("FAIL R2 missing answers %0d expected 0", q_go.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule